// File: doc/BRIEF.md
# Action-Qualified PWM Generator

This block is a single PWM generator channel. A 16-bit counter runs against a programmable period value, either counting down and reloading, or counting up to the period value and back down to zero. The counter produces six events. For each event, each of the two outputs (A and B) has its own 2-bit action code. The code can leave the output unchanged, toggle it, force it low or force it high. Placing these actions lets the caller build edge-aligned or centre-aligned waveforms, single pulses or complementary pairs without extra logic.

The period value, both compare values and both action words are double-buffered. A write can take effect on the next clock. It can also wait until the counter reaches zero. For the action words only, it can wait for the first zero after a shared global-update request, so that several channels switch together. Each event sets a sticky raw flag. Per-event enables build a level interrupt from the flags and a one-cycle trigger pulse from the live events. A counter-sync input restarts the count from zero.

Top module: `actpwm_gen`

## Requirements
- R1: After synchronous reset, `count` is 0, both PWM outputs are low, `raw_flags` is 0, and `irq` and `trig` are low. All held values (period, compares, action words) are 0.
- R2: With `updown`=0 and `en`=1, the counter decrements by one each clock. When it is at 0, it loads the period value in force, giving a period of P+1 clocks.
- R3: With `updown`=1 and `en`=1, the counter counts 0,1,…,P and then P-1,…,0, reversing at P and at 0, giving a period of 2P clocks.
- R4: An event acts on an output at the clock edge that ends the cycle in which the event is present. Action code 00 leaves the output unchanged, 01 inverts it, 10 drives it low, and 11 drives it high.
- R5: Event bit order is 0 zero, 1 count equals period, 2 compare A counting up, 3 compare A counting down, 4 compare B counting up, 5 compare B counting down. In action word bits [2k+1:2k], k is the event number. In down-only mode, only the down compare events occur.
- R6: When several events occur in the same cycle, the output takes the action of the highest-ranked event whose code is not 00. The ranking is zero, then period, then B down, B up, A down, and A up last.
- R7: `raw_flags` bit k is set by event k and stays set until `flag_clr` bit k is 1. When an event and its clear fall in the same cycle, the flag stays set.
- R8: `irq` is high whenever any `raw_flags` bit is set whose `irq_en` bit is set. `trig` is a one-cycle pulse one clock after any event whose `trig_en` bit is set.
- R9: When its sync select is 0, a period or compare write is in force from the next clock. When its sync select is 1, the value is held pending and comes into force in the first cycle the counter is at 0; a down-count reload in that cycle already uses the new period.
- R10: Action update mode 00 or 01 applies a write on the next clock. Mode 10 brings it into force at the next zero. Mode 11 holds it until the first zero that follows a `gupd_req` pulse.
- R11: With `sync_in`=1, `count` is 0 after the next clock edge.
- R12: With `en`=0, `count` is 0 and both outputs are low after the next edge, and no event fires, so no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| updown | input | 1 | 0 = down-only count, 1 = up then down |
| sync_in | input | 1 | Restart counter from zero |
| gupd_req | input | 1 | Global update request for mode-11 action writes |
| load_wdata | input | 16 | Period value write data |
| load_wr | input | 1 | Period write strobe |
| load_sync | input | 1 | Period update at zero (1) or immediate (0) |
| cmpa_wdata | input | 16 | Compare A write data |
| cmpa_wr | input | 1 | Compare A write strobe |
| cmpa_sync | input | 1 | Compare A update at zero (1) or immediate (0) |
| cmpb_wdata | input | 16 | Compare B write data |
| cmpb_wr | input | 1 | Compare B write strobe |
| cmpb_sync | input | 1 | Compare B update at zero (1) or immediate (0) |
| acta_wdata | input | 12 | Action word for output A |
| acta_wr | input | 1 | Action word A write strobe |
| acta_upd | input | 2 | Action A update mode |
| actb_wdata | input | 12 | Action word for output B |
| actb_wr | input | 1 | Action word B write strobe |
| actb_upd | input | 2 | Action B update mode |
| irq_en | input | 6 | Per-event interrupt enables |
| trig_en | input | 6 | Per-event trigger enables |
| flag_clr | input | 6 | Write-one-to-clear for raw flags |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| raw_flags | output | 6 | Sticky event flags |
| irq | output | 1 | Interrupt level |
| trig | output | 1 | Trigger pulse |
| count | output | 16 | Live counter value |

## Verification
Two functions can land in the same cycle. One case is two counter events acting on one output: compare A is set to 0, so the zero event and the compare-A-down event fire together, each with a conflicting action. The bench checks that the output follows the zero action, and that a lower-ranked event still acts when the zero code is 00. The other case is a flag being set and cleared at once: a flag clear is pulsed exactly in a cycle where the counter sits at zero, and the bench checks that the flag survives.

// File: rtl/actpwm_pkg.sv
package actpwm_pkg;

    localparam int EVN = 6;          // number of counter events
    localparam int AWW = 2 * EVN;    // action word width

    localparam int EV_ZERO = 0;
    localparam int EV_LOAD = 1;
    localparam int EV_AU   = 2;
    localparam int EV_AD   = 3;
    localparam int EV_BU   = 4;
    localparam int EV_BD   = 5;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_FLIP = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        UPD_NOW   = 2'b00,
        UPD_NOW1  = 2'b01,
        UPD_LOCAL = 2'b10,
        UPD_GLOB  = 2'b11
    } upd_e;

    // priority position p (0 = lowest) to event index
    function automatic int rank_to_event(input int p);
        return (p < 4) ? p + 2 : 5 - p;
    endfunction

    // winning action among the active events
    function automatic act_e pick_action(input logic [EVN-1:0] ev,
                                         input logic [AWW-1:0] word);
        act_e res;
        res = ACT_KEEP;
        for (int p = 0; p < EVN; p++) begin
            if (ev[rank_to_event(p)] && word[2*rank_to_event(p) +: 2] != 2'b00)
                res = act_e'(word[2*rank_to_event(p) +: 2]);
        end
        return res;
    endfunction

    function automatic logic apply_action(input logic cur, input act_e a);
        case (a)
            ACT_FLIP: return ~cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

    function automatic logic is_deferred(input upd_e m);
        return (m == UPD_LOCAL) || (m == UPD_GLOB);
    endfunction

endpackage

// File: rtl/actpwm_counter.sv
module actpwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          updown,
    input  logic          sync_clr,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          dir_up
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst || !en || sync_clr) begin
            cnt    <= ZERO;
            dir_up <= 1'b1;
        end else if (!updown) begin
            dir_up <= 1'b0;
            cnt    <= (cnt == ZERO) ? period : cnt - ONE;
        end else if (cnt == ZERO) begin
            dir_up <= 1'b1;
            cnt    <= (period == ZERO) ? ZERO : ONE;
        end else if (dir_up && cnt >= period) begin
            dir_up <= 1'b0;
            cnt    <= cnt - ONE;
        end else if (dir_up) begin
            cnt <= cnt + ONE;
        end else begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/actpwm_shadow.sv
module actpwm_shadow
    import actpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  upd_e         mode,
    input  logic         zero_tick,
    input  logic         gl_arm,
    output logic [W-1:0] val
);
    logic [W-1:0] cur_q, pdata_q;
    logic         pend_q, pglob_q, commit;

    // pending value comes into force in the zero cycle itself
    assign commit = zero_tick && pend_q && (!pglob_q || gl_arm);
    assign val    = commit ? pdata_q : cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            pdata_q <= '0;
            pend_q  <= 1'b0;
            pglob_q <= 1'b0;
        end else begin
            if (commit) cur_q <= pdata_q;
            if (wr && !is_deferred(mode)) begin
                cur_q  <= wdata;
                pend_q <= 1'b0;
            end else if (wr) begin
                pdata_q <= wdata;
                pend_q  <= 1'b1;
                pglob_q <= (mode == UPD_GLOB);
            end else if (commit) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/actpwm_out.sv
module actpwm_out
    import actpwm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [EVN-1:0] ev,
    input  logic [AWW-1:0] word,
    output logic           pwm
);
    always_ff @(posedge clk) begin
        if (rst || !en) pwm <= 1'b0;
        else            pwm <= apply_action(pwm, pick_action(ev, word));
    end
endmodule

// File: rtl/actpwm_gen.sv
module actpwm_gen
    import actpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           updown,
    input  logic           sync_in,
    input  logic           gupd_req,
    input  logic [CW-1:0]  load_wdata,
    input  logic           load_wr,
    input  logic           load_sync,
    input  logic [CW-1:0]  cmpa_wdata,
    input  logic           cmpa_wr,
    input  logic           cmpa_sync,
    input  logic [CW-1:0]  cmpb_wdata,
    input  logic           cmpb_wr,
    input  logic           cmpb_sync,
    input  logic [AWW-1:0] acta_wdata,
    input  logic           acta_wr,
    input  logic [1:0]     acta_upd,
    input  logic [AWW-1:0] actb_wdata,
    input  logic           actb_wr,
    input  logic [1:0]     actb_upd,
    input  logic [EVN-1:0] irq_en,
    input  logic [EVN-1:0] trig_en,
    input  logic [EVN-1:0] flag_clr,
    output logic           pwm_a,
    output logic           pwm_b,
    output logic [EVN-1:0] raw_flags,
    output logic           irq,
    output logic           trig,
    output logic [CW-1:0]  count
);
    localparam int NOUT = 2;

    logic [CW-1:0]  period_v, cmpa_v, cmpb_v;
    logic           dir_up, up_phase, zero_tick, garm_q;
    logic [EVN-1:0] ev;

    logic [AWW-1:0] act_wd   [NOUT];
    logic           act_wr   [NOUT];
    upd_e           act_md   [NOUT];
    logic [AWW-1:0] act_word [NOUT];
    logic           pwm_v    [NOUT];

    actpwm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .updown(updown), .sync_clr(sync_in),
        .period(period_v), .cnt(count), .dir_up(dir_up)
    );

    actpwm_shadow #(.W(CW)) u_sh_load (
        .clk(clk), .rst(rst), .wr(load_wr), .wdata(load_wdata),
        .mode(load_sync ? UPD_LOCAL : UPD_NOW), .zero_tick(zero_tick),
        .gl_arm(garm_q), .val(period_v)
    );
    actpwm_shadow #(.W(CW)) u_sh_cmpa (
        .clk(clk), .rst(rst), .wr(cmpa_wr), .wdata(cmpa_wdata),
        .mode(cmpa_sync ? UPD_LOCAL : UPD_NOW), .zero_tick(zero_tick),
        .gl_arm(garm_q), .val(cmpa_v)
    );
    actpwm_shadow #(.W(CW)) u_sh_cmpb (
        .clk(clk), .rst(rst), .wr(cmpb_wr), .wdata(cmpb_wdata),
        .mode(cmpb_sync ? UPD_LOCAL : UPD_NOW), .zero_tick(zero_tick),
        .gl_arm(garm_q), .val(cmpb_v)
    );

    // counter events, all gated by the channel enable
    assign up_phase      = updown & dir_up;
    assign ev[EV_ZERO]   = en && (count == '0);
    assign ev[EV_LOAD]   = en && (count == period_v);
    assign ev[EV_AU]     = en && (count == cmpa_v) && up_phase;
    assign ev[EV_AD]     = en && (count == cmpa_v) && !up_phase;
    assign ev[EV_BU]     = en && (count == cmpb_v) && up_phase;
    assign ev[EV_BD]     = en && (count == cmpb_v) && !up_phase;
    assign zero_tick     = ev[EV_ZERO];

    assign act_wd[0] = acta_wdata;
    assign act_wd[1] = actb_wdata;
    assign act_wr[0] = acta_wr;
    assign act_wr[1] = actb_wr;
    assign act_md[0] = upd_e'(acta_upd);
    assign act_md[1] = upd_e'(actb_upd);

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        actpwm_shadow #(.W(AWW)) u_sh_act (
            .clk(clk), .rst(rst), .wr(act_wr[g]), .wdata(act_wd[g]),
            .mode(act_md[g]), .zero_tick(zero_tick), .gl_arm(garm_q),
            .val(act_word[g])
        );
        actpwm_out u_out (
            .clk(clk), .rst(rst), .en(en), .ev(ev),
            .word(act_word[g]), .pwm(pwm_v[g])
        );
    end

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];

    // global arm: set by request, consumed by the next zero
    always_ff @(posedge clk) begin
        if (rst)            garm_q <= 1'b0;
        else if (zero_tick) garm_q <= gupd_req;
        else if (gupd_req)  garm_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_flags <= '0;
            trig      <= 1'b0;
        end else begin
            raw_flags <= (raw_flags & ~flag_clr) | ev;
            trig      <= |(ev & trig_en);
        end
    end

    assign irq = |(raw_flags & irq_en);
endmodule

// File: rtl/actpwm_chk.sv
module actpwm_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          updown,
    input logic          sync_in,
    input logic [5:0]    flag_clr,
    input logic [5:0]    trig_en,
    input logic [CW-1:0] count,
    input logic          pwm_a,
    input logic          pwm_b,
    input logic [5:0]    raw_flags,
    input logic          trig
);
    p_dis_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !en |=> (count == '0 && !pwm_a && !pwm_b));

    p_sync_clr_r11: assert property (@(posedge clk) disable iff (rst)
        (en && sync_in) |=> (count == '0));

    p_down_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !updown && !sync_in && count != '0) |=> (count == $past(count) - CW'(1)));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (raw_flags != 6'd0) |=> ((($past(raw_flags) & ~$past(flag_clr)) & ~raw_flags) == 6'd0));

    p_trig_src_r8: assert property (@(posedge clk) disable iff (rst)
        trig |-> ($past(trig_en) != 6'd0 && $past(en)));
endmodule

bind actpwm_gen actpwm_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .en(en), .updown(updown), .sync_in(sync_in),
    .flag_clr(flag_clr), .trig_en(trig_en), .count(count),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .raw_flags(raw_flags), .trig(trig)
);

// File: tb/actpwm_gen_tb.sv
module actpwm_gen_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, en, updown, sync_in, gupd_req;
    logic [15:0] load_wdata, cmpa_wdata, cmpb_wdata;
    logic        load_wr, load_sync, cmpa_wr, cmpa_sync, cmpb_wr, cmpb_sync;
    logic [11:0] acta_wdata, actb_wdata;
    logic        acta_wr, actb_wr;
    logic [1:0]  acta_upd, actb_upd;
    logic [5:0]  irq_en, trig_en, flag_clr;
    logic        pwm_a, pwm_b, irq, trig;
    logic [5:0]  raw_flags;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;

    actpwm_gen dut_i (
        .clk(clk), .rst(rst), .en(en), .updown(updown), .sync_in(sync_in),
        .gupd_req(gupd_req), .load_wdata(load_wdata), .load_wr(load_wr),
        .load_sync(load_sync), .cmpa_wdata(cmpa_wdata), .cmpa_wr(cmpa_wr),
        .cmpa_sync(cmpa_sync), .cmpb_wdata(cmpb_wdata), .cmpb_wr(cmpb_wr),
        .cmpb_sync(cmpb_sync), .acta_wdata(acta_wdata), .acta_wr(acta_wr),
        .acta_upd(acta_upd), .actb_wdata(actb_wdata), .actb_wr(actb_wr),
        .actb_upd(actb_upd), .irq_en(irq_en), .trig_en(trig_en),
        .flag_clr(flag_clr), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .raw_flags(raw_flags), .irq(irq), .trig(trig), .count(count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic wait_cnt(input int v);
        int n = 0;
        do begin
            tick();
            n++;
        end while (count != 16'(v) && n < 300);
    endtask

    task automatic do_reset;
        rst = 1'b1; en = 0; updown = 0; sync_in = 0; gupd_req = 0;
        load_wdata = 0; load_wr = 0; load_sync = 0;
        cmpa_wdata = 0; cmpa_wr = 0; cmpa_sync = 0;
        cmpb_wdata = 0; cmpb_wr = 0; cmpb_sync = 0;
        acta_wdata = 0; acta_wr = 0; acta_upd = 0;
        actb_wdata = 0; actb_wr = 0; actb_upd = 0;
        irq_en = 0; trig_en = 0; flag_clr = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic wr_load(input int v);
        load_wdata = 16'(v); load_wr = 1; tick(); load_wr = 0;
    endtask
    task automatic wr_cmpa(input int v);
        cmpa_wdata = 16'(v); cmpa_wr = 1; tick(); cmpa_wr = 0;
    endtask
    task automatic wr_cmpb(input int v);
        cmpb_wdata = 16'(v); cmpb_wr = 1; tick(); cmpb_wr = 0;
    endtask
    task automatic wr_acta(input int v);
        acta_wdata = 12'(v); acta_wr = 1; tick(); acta_wr = 0;
    endtask
    task automatic wr_actb(input int v);
        actb_wdata = 12'(v); actb_wr = 1; tick(); actb_wr = 0;
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 pwm_a", pwm_a, 0);
        chk("R1 pwm_b", pwm_b, 0);
        chk("R1 flags", raw_flags, 0);
        chk("R1 irq", irq, 0);
        chk("R1 trig", trig, 0);
        tick(); tick();
        chk("R12 idle count", count, 0);
    endtask

    // down mode: A high on zero, low on compare A down; B toggles on period
    task automatic t_down;
        int prev;
        int b1;
        do_reset();
        wr_load(4); wr_cmpa(2); wr_cmpb(3);
        wr_acta(12'h083); wr_actb(12'h004);
        trig_en = 6'b000010;
        en = 1; tick();
        wait_cnt(0);
        prev = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            chk("R2 down sequence", count, (prev == 0) ? 4 : prev - 1);
            chk("R4 R5 pwm_a level", pwm_a, (count >= 2) ? 1 : 0);
            chk("R8 trig pulse", trig, (count == 3) ? 1 : 0);
            prev = count;
        end
        wait_cnt(3); b1 = pwm_b;
        wait_cnt(3);
        chk("R4 toggle code", pwm_b, 1 - b1);
        wait_cnt(2);
        sync_in = 1; tick(); sync_in = 0;
        chk("R11 sync clears", count, 0);
        tick();
        chk("R11 restart reload", count, 4);
        wait_cnt(0);
        flag_clr = 6'b000001; tick(); flag_clr = 0;
        chk("R7 set wins over clear", raw_flags[0], 1);
        en = 0; tick();
        chk("R12 count held", count, 0);
        chk("R12 pwm_a low", pwm_a, 0);
        chk("R12 pwm_b low", pwm_b, 0);
        chk("R5 R7 down flags", raw_flags, 6'b101011);
        irq_en = 6'b001000; #1;
        chk("R8 irq on", irq, 1);
        irq_en = 6'b000100; #1;
        chk("R8 irq masked", irq, 0);
        flag_clr = 6'b001000; tick(); flag_clr = 0;
        chk("R7 single clear", raw_flags, 6'b100011);
        flag_clr = 6'b111111; tick(); flag_clr = 0;
        tick(); tick();
        chk("R12 no events when off", raw_flags, 0);
        chk("R12 no trig when off", trig, 0);
    endtask

    task automatic t_updown;
        int exp_seq[8] = '{1, 2, 3, 4, 3, 2, 1, 0};
        do_reset();
        wr_load(4); wr_cmpa(2); wr_cmpb(3);
        wr_acta(12'h0B0);
        updown = 1; en = 1; tick();
        wait_cnt(0);
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R3 updown sequence", count, exp_seq[i]);
        end
        wait_cnt(4);
        chk("R5 compare up high", pwm_a, 1);
        wait_cnt(0);
        chk("R5 compare down low", pwm_a, 0);
        chk("R5 R7 all six flags", raw_flags, 6'h3F);
        wait_cnt(0);
        tick();
        load_wdata = 16'd2; load_wr = 1; tick(); load_wr = 0;
        chk("R9 immediate step", count, 2);
        tick();
        chk("R9 immediate reverse", count, 1);
    endtask

    // zero and compare A down coincide when compare A is 0
    task automatic t_prio;
        int b1;
        do_reset();
        wr_load(4); wr_cmpa(0);
        wr_acta(12'h083); wr_actb(12'h040);
        en = 1; tick();
        wait_cnt(0); wait_cnt(4);
        for (int i = 0; i < 10; i++) begin
            tick();
            chk("R6 zero outranks compare", pwm_a, 1);
        end
        wait_cnt(4); b1 = pwm_b;
        wait_cnt(4);
        chk("R6 lower rank acts when zero keeps", pwm_b, 1 - b1);
    endtask

    task automatic t_shadow;
        do_reset();
        wr_load(4); wr_cmpa(2); wr_acta(12'h083);
        load_sync = 1; acta_upd = 2'b11; actb_upd = 2'b10;
        en = 1; tick();
        wait_cnt(2);
        load_wdata = 16'd6; load_wr = 1; tick(); load_wr = 0;
        chk("R9 pending step", count, 1);
        tick();
        chk("R9 pending zero", count, 0);
        tick();
        chk("R9 reload uses new period", count, 6);
        wr_acta(12'h0C2);
        wait_cnt(0);
        for (int i = 0; i < 14; i++) begin
            tick();
            chk("R10 global held", pwm_a, (count >= 2) ? 1 : 0);
        end
        wait_cnt(3);
        wr_actb(12'h003);
        chk("R10 local pending", pwm_b, 0);
        wait_cnt(6);
        chk("R10 local at zero", pwm_b, 1);
        gupd_req = 1; tick(); gupd_req = 0;
        wait_cnt(6);
        for (int i = 0; i < 14; i++) begin
            tick();
            chk("R10 global applied", pwm_a, (count < 2) ? 1 : 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_down();
        t_updown();
        t_prio();
        t_shadow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule